// File: doc/BRIEF.md
# Upstream Buffer Flush Timer with Send-Immediate

This block decides when the bytes waiting in an upstream (device-to-host) buffer may go out on the next host IN request. It does not build packets. It gives a release permit, and a tag that says whether the release is short or zero-length. A full packet always goes out at once.

A partly filled buffer waits until one of two things happens. The first is that an idle timer expires. This timer counts millisecond ticks since the last byte entered the buffer. Its limit can be set from 1 to 255 and is 16 after reset. The second is a send-immediate strobe: a falling edge on the active-low `si_n` pin while the link is active. The same pin asks the host to resume when the link is suspended, but only if remote wakeup is enabled. With wakeup disabled, a strobe during suspend does nothing.

The control state machine has three states:
- `ST_WAIT`: the timer is running. It moves to `ST_EXPIRED` when the timer reaches its limit with data present.
- `ST_EXPIRED`: a short release is armed. It returns to `ST_WAIT` on an IN request or on a new byte.
- `ST_FORCE`: a send-immediate is pending. It returns to `ST_WAIT` on the IN request that serves it.

A send-immediate strobe while the link is active moves `ST_WAIT` or `ST_EXPIRED` to `ST_FORCE`.

Top module: `ul_flush_ctrl`

## Requirements
- R1: After reset the flush limit is 16 ticks, the state is ST_WAIT and all four outputs are 0. With data present, an IN request after 15 ticks releases nothing; after 16 ticks it releases a short packet.
- R2: A pulse on `tmo_wr` with `tmo_wdata` in 1..255 sets the limit. A write of 0 is ignored and the previous limit stays.
- R3: An IN request when `fill_level` >= 64 gives `flush_ok`=1 with `short_rel`=0 and `zlp_rel`=0 one cycle later, whatever the timer state.
- R4: An IN request with 0 < `fill_level` < 64, no expiry and no pending strobe releases nothing.
- R5: Once the limit is reached with `fill_level` > 0, the next IN request gives `flush_ok`=1 and `short_rel`=1. With the buffer empty, reaching the limit arms nothing.
- R6: `byte_push` restarts the idle count from zero.
- R7: A falling edge of `si_n` while not suspended makes the next IN request release. That release is short when data is present.
- R8: If the buffer is empty when a pending strobe is served, `zlp_rel`=1. The pending state then clears, so a second IN request releases nothing.
- R9: A falling edge of `si_n` while suspended with `rwake_en`=1 gives a one-cycle `resume_req` pulse and leaves no flush pending.
- R10: A falling edge of `si_n` while suspended with `rwake_en`=0 gives no `resume_req` and leaves no flush pending.
- R11: All outputs are registered one-cycle pulses. `flush_ok` only follows an IN request in the previous cycle. `short_rel` and `zlp_rel` never rise together, and either one implies `flush_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| byte_push | input | 1 | A byte entered the buffer this cycle |
| fill_level | input | LVL_W | Bytes currently held in the buffer |
| in_req | input | 1 | Host IN request pulse |
| suspended | input | 1 | Link is suspended |
| rwake_en | input | 1 | Remote wakeup allowed |
| si_n | input | 1 | Active-low send-immediate / wakeup strobe |
| tmo_wr | input | 1 | Load a new flush limit |
| tmo_wdata | input | TMO_W | Flush limit in ticks |
| flush_ok | output | 1 | Release permit for the served IN request |
| short_rel | output | 1 | The release is a short packet |
| zlp_rel | output | 1 | The release is zero-length |
| resume_req | output | 1 | Pulse asking the host to resume |

## Verification
The bench builds the block with its default parameters: a 9-bit fill level, 64-byte packets and an 8-bit limit. The reset limit of 16 can therefore be tested at its exact boundary. For most cases the bench loads a limit of 4, so expiry, restart by a new byte and the off-by-one tick boundary are each reached within a few ticks. Fill levels of 0, 10, 64 and 200 cover the empty, short, exact-packet and over-packet release paths.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_EXPIRED = 2'd1,
        ST_FORCE   = 2'd2
    } ufc_state_e;
endpackage

// File: rtl/ufc_tmo_reg.sv
// Holds the flush limit; zero writes are discarded.
module ufc_tmo_reg #(
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [TMO_W-1:0] wdata,
    output logic [TMO_W-1:0] limit
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= TMO_W'(TMO_RST);
        else if (wr && (wdata != '0))
            limit <= wdata;
    end
endmodule

// File: rtl/ufc_idle_timer.sv
// Counts ms ticks since last clear, saturating at the limit.
module ufc_idle_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [TMO_W-1:0] limit,
    output logic             reached
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (tick && (cnt_q < limit))
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q >= limit);
endmodule

// File: rtl/ufc_strobe.sv
// Detects falling edge of the strobe and routes it by link state.
module ufc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic si_n,
    input  logic suspended,
    input  logic rwake_en,
    output logic si_flush,
    output logic wake_set
);
    logic si_q;
    logic fall;

    always_ff @(posedge clk) begin
        if (!rst_n)
            si_q <= 1'b1;
        else
            si_q <= si_n;
    end

    assign fall     = si_q && !si_n;
    assign si_flush = fall && !suspended;
    assign wake_set = fall && suspended && rwake_en;
endmodule

// File: rtl/ul_flush_ctrl.sv
module ul_flush_ctrl #(
    parameter int LVL_W     = 9,
    parameter int PKT_BYTES = 64,
    parameter int TMO_W     = 8,
    parameter int TMO_RST   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             byte_push,
    input  logic [LVL_W-1:0] fill_level,
    input  logic             in_req,
    input  logic             suspended,
    input  logic             rwake_en,
    input  logic             si_n,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_wdata,
    output logic             flush_ok,
    output logic             short_rel,
    output logic             zlp_rel,
    output logic             resume_req
);
    import ufc_pkg::*;

    localparam logic [LVL_W-1:0] PKT_LVL = LVL_W'(PKT_BYTES);

    ufc_state_e       state, nxt;
    logic [TMO_W-1:0] tmo_q;
    logic             tmr_reached;
    logic             si_flush, wake_set;
    logic             has_data, full_pkt;
    logic             rel_now, short_now, zlp_now;

    assign has_data = (fill_level != '0);
    assign full_pkt = (fill_level >= PKT_LVL);

    ufc_tmo_reg #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) tmo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tmo_wr),
        .wdata (tmo_wdata),
        .limit (tmo_q)
    );

    ufc_idle_timer #(.TMO_W(TMO_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ms_tick),
        .clr     (byte_push || rel_now),
        .limit   (tmo_q),
        .reached (tmr_reached)
    );

    ufc_strobe strb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .si_n      (si_n),
        .suspended (suspended),
        .rwake_en  (rwake_en),
        .si_flush  (si_flush),
        .wake_set  (wake_set)
    );

    // release decision for the IN request of this cycle
    always_comb begin
        rel_now   = in_req && (full_pkt || (state == ST_FORCE) ||
                               ((state == ST_EXPIRED) && has_data));
        short_now = in_req && !full_pkt && has_data &&
                    ((state == ST_FORCE) || (state == ST_EXPIRED));
        zlp_now   = in_req && (state == ST_FORCE) && !has_data;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: begin
                if (si_flush)
                    nxt = ST_FORCE;
                else if (tmr_reached && has_data)
                    nxt = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (si_flush)
                    nxt = ST_FORCE;
                else if (in_req || byte_push)
                    nxt = ST_WAIT;
            end
            ST_FORCE: begin
                if (in_req && !si_flush)
                    nxt = ST_WAIT;
            end
            default: nxt = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_WAIT;
        else
            state <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_ok   <= 1'b0;
            short_rel  <= 1'b0;
            zlp_rel    <= 1'b0;
            resume_req <= 1'b0;
        end else begin
            flush_ok   <= rel_now;
            short_rel  <= short_now;
            zlp_rel    <= zlp_now;
            resume_req <= wake_set;
        end
    end
endmodule

// File: rtl/ufc_chk.sv
module ufc_chk #(
    parameter int LVL_W     = 9,
    parameter int PKT_BYTES = 64,
    parameter int TMO_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] fill_level,
    input logic             in_req,
    input logic             suspended,
    input logic             rwake_en,
    input logic             tmo_wr,
    input logic [TMO_W-1:0] tmo_q,
    input logic             flush_ok,
    input logic             short_rel,
    input logic             zlp_rel,
    input logic             resume_req
);
    // R2
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tmo_wr) |-> $stable(tmo_q));

    // R2
    limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q != '0);

    // R3
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && (fill_level >= LVL_W'(PKT_BYTES))) |=> (flush_ok && !short_rel && !zlp_rel));

    // R8
    zlp_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_rel |-> ($past(fill_level) == '0));

    // R9
    resume_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(suspended));

    // R10
    resume_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(rwake_en));

    // R11
    flush_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ok |-> $past(in_req));

    // R11
    tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_rel && zlp_rel));

    // R11
    tag_needs_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_rel || zlp_rel) |-> flush_ok);
endmodule

bind ul_flush_ctrl ufc_chk #(.LVL_W(LVL_W), .PKT_BYTES(PKT_BYTES), .TMO_W(TMO_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .in_req     (in_req),
    .suspended  (suspended),
    .rwake_en   (rwake_en),
    .tmo_wr     (tmo_wr),
    .tmo_q      (tmo_q),
    .flush_ok   (flush_ok),
    .short_rel  (short_rel),
    .zlp_rel    (zlp_rel),
    .resume_req (resume_req)
);

// File: tb/ul_flush_ctrl_tb_top.sv
`timescale 1ns/1ps
module ul_flush_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       byte_push = 1'b0;
    logic [8:0] fill_level = '0;
    logic       in_req = 1'b0;
    logic       suspended = 1'b0;
    logic       rwake_en = 1'b0;
    logic       si_n = 1'b1;
    logic       tmo_wr = 1'b0;
    logic [7:0] tmo_wdata = '0;
    logic       flush_ok, short_rel, zlp_rel, resume_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ul_flush_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .byte_push(byte_push),
        .fill_level(fill_level), .in_req(in_req), .suspended(suspended),
        .rwake_en(rwake_en), .si_n(si_n), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
        .flush_ok(flush_ok), .short_rel(short_rel), .zlp_rel(zlp_rel),
        .resume_req(resume_req)
    );

    // vector: fill[20:12] ticks[11:4] si[3] exp flush[2] short[1] zlp[0]; limit = 4
    localparam logic [20:0] VEC [8] = '{
        {9'd10,  8'd0, 1'b0, 3'b000},  // R4
        {9'd64,  8'd0, 1'b0, 3'b100},  // R3
        {9'd200, 8'd5, 1'b0, 3'b100},  // R3
        {9'd10,  8'd3, 1'b0, 3'b000},  // R5 boundary
        {9'd10,  8'd4, 1'b0, 3'b110},  // R5
        {9'd10,  8'd0, 1'b1, 3'b110},  // R7
        {9'd0,   8'd0, 1'b1, 3'b101},  // R8
        {9'd0,   8'd6, 1'b0, 3'b000}   // R5 empty
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push();
        @(negedge clk) byte_push = 1'b1;
        @(negedge clk) byte_push = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk) si_n = 1'b0;
        @(negedge clk) si_n = 1'b1;
    endtask

    task automatic set_limit(input logic [7:0] v);
        @(negedge clk) begin tmo_wr = 1'b1; tmo_wdata = v; end
        @(negedge clk) tmo_wr = 1'b0;
    endtask

    // idle cycle, then IN request; outputs sampled one cycle later
    task automatic serve(input string req, input int ef, input int es, input int ez);
        @(negedge clk);
        in_req = 1'b1;
        @(negedge clk);
        in_req = 1'b0;
        chk({req, " flush"}, int'(flush_ok), ef);
        chk({req, " short"}, int'(short_rel), es);
        chk({req, " zlp"}, int'(zlp_rel), ez);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk("R1 rst flush", int'(flush_ok), 0);
        chk("R1 rst resume", int'(resume_req), 0);

        // R1 default limit 16
        fill_level = 9'd10;
        push();
        ticks(15);
        serve("R1 15 ticks", 0, 0, 0);
        ticks(1);
        serve("R1 16 ticks", 1, 1, 0);

        // R2 load limit 4, then the table
        set_limit(8'd4);
        for (int v = 0; v < 8; v++) begin
            fill_level = VEC[v][20:12];
            push();
            if (VEC[v][3]) strobe();
            ticks(int'(VEC[v][11:4]));
            serve($sformatf("R2 vec%0d", v), int'(VEC[v][2]), int'(VEC[v][1]), int'(VEC[v][0]));
        end

        // R2 zero write rejected: limit still 4
        set_limit(8'd0);
        fill_level = 9'd10;
        push();
        ticks(3);
        serve("R2 zero wr 3", 0, 0, 0);
        ticks(1);
        serve("R2 zero wr 4", 1, 1, 0);

        // R6 new byte restarts count
        push();
        ticks(3);
        push();
        ticks(3);
        serve("R6 restart", 0, 0, 0);
        ticks(1);
        serve("R6 after", 1, 1, 0);

        // R8 pending clears after zero-length release
        fill_level = 9'd0;
        push();
        strobe();
        serve("R8 zlp", 1, 0, 1);
        serve("R8 cleared", 0, 0, 0);

        // R9 wakeup while suspended
        suspended = 1'b1;
        rwake_en  = 1'b1;
        @(negedge clk) si_n = 1'b0;
        @(negedge clk) si_n = 1'b1;
        chk("R9 resume pulse", int'(resume_req), 1);
        @(negedge clk);
        chk("R9 resume one cycle", int'(resume_req), 0);
        suspended = 1'b0;
        fill_level = 9'd10;
        push();
        serve("R9 no pending", 0, 0, 0);

        // R10 wakeup disabled
        suspended = 1'b1;
        rwake_en  = 1'b0;
        @(negedge clk) si_n = 1'b0;
        @(negedge clk) si_n = 1'b1;
        chk("R10 no resume", int'(resume_req), 0);
        suspended = 1'b0;
        push();
        serve("R10 no pending", 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule